// File: doc/BRIEF.md
# Eight-Bank Bit-Reversal Reorder Unit

The unit holds eight banks, each with one row of N complex fixed-point samples (N = 2^LOG2N). It puts every bank into bit-reversed index order before an FFT's butterfly stages run. One address counter and its bit-reversed mirror drive all eight banks in the same cycle, so the eight rows are permuted in parallel. A single mode input picks the pass type. In the row pass each sample is also scaled down by an arithmetic right shift. In the column pass the samples are only moved.

While the unit is idle, an external mover fills the banks through a write port. Software or a DMA pulses `start` and waits for `done`, then reads the reordered rows back through a combinational read port. The counter visits indices 0 to N-1. A pair is exchanged only at the lower index of the pair, and each exchange costs one extra cycle. The mode and the shift amount are captured when the run is accepted.

Top module: `bitrev_reorder`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: With `row_mode`=0 (pure reorder), after a run the entry at address j of every bank holds the value that was at address rev(j) before the run. rev reverses the LOG2N address bits. The samples are not scaled.
- R3: With `row_mode`=1 (scale and reorder), after a run the entry at address j holds the former entry rev(j), with its real and imaginary parts each arithmetically shifted right by `shift_amt`. The sign is preserved, and each sample is shifted exactly once.
- R4: A `shift_amt` value greater than LOG2N is treated as LOG2N.
- R5: All eight banks (`fill_row`/`rd_row` 0..7) receive the same permutation in the same run, and each bank keeps its own data.
- R6: Let S be the number of indices i with rev(i) > i. If `start` is sampled at rising edge 1, `done` is high after rising edge N+S+1 for exactly one cycle. The unit is idle again after the following edge.
- R7: `busy` is high from the edge that accepts `start` until the cycle after `done`. A `start` pulse while busy is ignored and does not restart or extend the run.
- R8: Changes to `row_mode` or `shift_amt` after the run has been accepted have no effect on that run.
- R9: Fill-port writes (`fill_we`=1) while `busy` is high are ignored.
- R10: `row_mode`=1 with `shift_amt`=0 gives the same result as pure reorder.
- R11: Two back-to-back pure-reorder runs restore the original order in every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| row_mode | input | 1 | 1 = scale and reorder, 0 = reorder only |
| shift_amt | input | $clog2(LOG2N+1) | Right-shift amount for the scaled pass |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fill_we | input | 1 | Bank write strobe (ignored while busy) |
| fill_row | input | 3 | Bank selected for writing |
| fill_addr | input | LOG2N | Write address inside the bank |
| fill_re | input | 16 | Real part to write |
| fill_im | input | 16 | Imaginary part to write |
| rd_row | input | 3 | Bank selected for reading |
| rd_addr | input | LOG2N | Read address inside the bank |
| rd_re | output | 16 | Real part at the read address |
| rd_im | output | 16 | Imaginary part at the read address |

## Verification
The bench targets the cases where a reorder unit typically goes wrong:
- **Swapping each pair twice.** This leaves a bank in its original order, which the bit-reverse model catches for N = 8, 64 and 512.
- **Shifting too often or not at all.** Scaling a self-mapped index twice, or missing it, shows up as a wrong value only at the palindromic addresses. Negative samples expose a logical shift used in place of an arithmetic one.
- **Missing clamp.** A shift amount above LOG2N without the clamp yields different values.
- **Wrong timing.** A miscounted swap cycle moves `done` away from edge N+S+1.
- **Disturbances during a run.** The bench toggles the mode, re-pulses `start` and writes the fill port mid-run. Any effect appears as corrupted data or altered timing.

// File: rtl/brr_pkg.sv
package brr_pkg;

    localparam int SMP_W    = 16;
    localparam int NUM_ROWS = 8;
    localparam int ROW_W    = $clog2(NUM_ROWS);

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } smp_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SWAP,
        ST_FIN
    } brr_state_e;

    // Optional arithmetic down-scaling of both halves of a sample.
    function automatic smp_t scale_smp(input smp_t s, input logic en, input int unsigned sh);
        smp_t o;
        o = s;
        if (en) begin
            o.re = s.re >>> sh;
            o.im = s.im >>> sh;
        end
        return o;
    endfunction

endpackage

// File: rtl/brr_ctrl.sv
module brr_ctrl
    import brr_pkg::*;
#(
    parameter  int LOG2N = 6,
    localparam int SHW   = $clog2(LOG2N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_in,
    input  logic [SHW-1:0]   shift_in,
    output logic             busy,
    output logic             done,
    output logic [LOG2N-1:0] idx_o,
    output logic [LOG2N-1:0] ridx_o,
    output logic             self_we,
    output logic             swap_we,
    output logic             scale_on,
    output logic [SHW-1:0]   shift_o
);

    localparam logic [SHW-1:0]   SH_MAX   = SHW'(LOG2N);
    localparam logic [LOG2N-1:0] IDX_LAST = {LOG2N{1'b1}};

    brr_state_e       st_q;
    logic [LOG2N-1:0] idx_q;
    logic [LOG2N-1:0] ridx;
    logic             mode_q;
    logic [SHW-1:0]   sh_q;
    logic [SHW-1:0]   sh_lim;
    logic             upper;

    // Mirror of the counter: bit b of the reversed index is bit LOG2N-1-b.
    for (genvar b = 0; b < LOG2N; b++) begin : g_rev
        assign ridx[b] = idx_q[LOG2N-1-b];
    end

    assign sh_lim = (shift_in > SH_MAX) ? SH_MAX : shift_in;
    assign upper  = (ridx > idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            mode_q <= 1'b0;
            sh_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_SCAN;
                        idx_q  <= '0;
                        mode_q <= mode_in;
                        sh_q   <= sh_lim;
                    end
                end
                ST_SCAN: begin
                    if (upper) begin
                        st_q <= ST_SWAP;
                    end else if (idx_q == IDX_LAST) begin
                        st_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_SWAP: begin
                    idx_q <= idx_q + 1'b1;
                    st_q  <= ST_SCAN;
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_FIN);
    assign idx_o    = idx_q;
    assign ridx_o   = ridx;
    assign self_we  = (st_q == ST_SCAN) && (ridx == idx_q) && mode_q;
    assign swap_we  = (st_q == ST_SWAP);
    assign scale_on = mode_q;
    assign shift_o  = sh_q;

    // R6: the end-of-run pulse lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a non-swapping scan of a non-final index advances the counter by one
    a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SCAN && !upper && idx_q != IDX_LAST) |=> (idx_q == $past(idx_q) + 1'b1));

    // R7: once running, the unit stays busy until the done pulse
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R7: busy only drops right after done
    a_r7_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R8: captured mode and shift stay fixed during a run
    a_r8_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(mode_q) && $stable(sh_q)));

    // R4: the captured shift never exceeds LOG2N
    a_r4_shift_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sh_q <= SH_MAX));

endmodule

// File: rtl/brr_bank.sv
module brr_bank
    import brr_pkg::*;
#(
    parameter  int LOG2N = 6,
    localparam int N     = 1 << LOG2N,
    localparam int SHW   = $clog2(LOG2N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_we,
    input  logic [LOG2N-1:0] fill_addr,
    input  smp_t             fill_data,
    input  logic [LOG2N-1:0] a_addr,
    input  logic [LOG2N-1:0] b_addr,
    input  logic             self_we,
    input  logic             swap_we,
    input  logic             scale_on,
    input  logic [SHW-1:0]   shift,
    input  logic [LOG2N-1:0] rd_addr,
    output smp_t             rd_data
);

    smp_t mem [N];
    smp_t a_q, b_q, a_new, b_new;
    logic op_we;

    assign a_q   = mem[a_addr];
    assign b_q   = mem[b_addr];
    // Cross-write; for a self-mapped index a_addr == b_addr, so both writes agree.
    assign a_new = scale_smp(b_q, scale_on, shift);
    assign b_new = scale_smp(a_q, scale_on, shift);
    assign op_we = self_we | swap_we;

    always_ff @(posedge clk) begin
        if (fill_we) begin
            mem[fill_addr] <= fill_data;
        end else if (op_we) begin
            mem[a_addr] <= a_new;
            mem[b_addr] <= b_new;
        end
    end

    assign rd_data = mem[rd_addr];

    // R9: the fill port never competes with the reorder datapath
    a_r9_fill_excl: assert property (@(posedge clk) disable iff (rst)
        !(fill_we && op_we));

    // R2: an unscaled swap exchanges the two entries exactly
    a_r2_swap_exchange: assert property (@(posedge clk) disable iff (rst)
        (swap_we && !scale_on && !fill_we) |=>
            ((mem[$past(a_addr)] == $past(b_q)) && (mem[$past(b_addr)] == $past(a_q))));

endmodule

// File: rtl/bitrev_reorder.sv
module bitrev_reorder
    import brr_pkg::*;
#(
    parameter  int LOG2N = 6,
    localparam int SHW   = $clog2(LOG2N + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    row_mode,
    input  logic [SHW-1:0]          shift_amt,
    output logic                    busy,
    output logic                    done,
    input  logic                    fill_we,
    input  logic [ROW_W-1:0]        fill_row,
    input  logic [LOG2N-1:0]        fill_addr,
    input  logic [SMP_W-1:0]        fill_re,
    input  logic [SMP_W-1:0]        fill_im,
    input  logic [ROW_W-1:0]        rd_row,
    input  logic [LOG2N-1:0]        rd_addr,
    output logic [SMP_W-1:0]        rd_re,
    output logic [SMP_W-1:0]        rd_im
);

    logic [LOG2N-1:0] idx, ridx;
    logic             self_we, swap_we, scale_on;
    logic [SHW-1:0]   shift_q;
    smp_t             fill_data;
    smp_t             rd_bus [NUM_ROWS];

    assign fill_data.re = fill_re;
    assign fill_data.im = fill_im;

    brr_ctrl #(.LOG2N(LOG2N)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_in  (row_mode),
        .shift_in (shift_amt),
        .busy     (busy),
        .done     (done),
        .idx_o    (idx),
        .ridx_o   (ridx),
        .self_we  (self_we),
        .swap_we  (swap_we),
        .scale_on (scale_on),
        .shift_o  (shift_q)
    );

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_bank
        logic bank_fill;
        assign bank_fill = fill_we && !busy && (fill_row == ROW_W'(g));

        brr_bank #(.LOG2N(LOG2N)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .fill_we   (bank_fill),
            .fill_addr (fill_addr),
            .fill_data (fill_data),
            .a_addr    (idx),
            .b_addr    (ridx),
            .self_we   (self_we),
            .swap_we   (swap_we),
            .scale_on  (scale_on),
            .shift     (shift_q),
            .rd_addr   (rd_addr),
            .rd_data   (rd_bus[g])
        );
    end

    assign rd_re = rd_bus[rd_row].re;
    assign rd_im = rd_bus[rd_row].im;

endmodule

// File: tb/bitrev_reorder_tb.sv
module brr_harness #(
    parameter int LOG2N = 6
) (
    input  logic clk,
    input  logic rst,
    output logic fin,
    output int   errs,
    output int   chks
);
    localparam int N   = 1 << LOG2N;
    localparam int SHW = $clog2(LOG2N + 1);

    typedef struct {
        int          row;
        int          addr;
        logic [15:0] re;
        logic [15:0] im;
    } exp_t;

    logic             start, row_mode, busy, done, fill_we;
    logic [SHW-1:0]   shift_amt;
    logic [2:0]       fill_row, rd_row;
    logic [LOG2N-1:0] fill_addr, rd_addr;
    logic [15:0]      fill_re, fill_im, rd_re, rd_im;

    logic [15:0] mre [8][N];
    logic [15:0] mim [8][N];
    exp_t        q [$];

    bitrev_reorder #(.LOG2N(LOG2N)) u_dut (
        .clk(clk), .rst(rst), .start(start), .row_mode(row_mode),
        .shift_amt(shift_amt), .busy(busy), .done(done),
        .fill_we(fill_we), .fill_row(fill_row), .fill_addr(fill_addr),
        .fill_re(fill_re), .fill_im(fill_im),
        .rd_row(rd_row), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im)
    );

    function automatic int brev(input int v);
        int o = 0;
        for (int b = 0; b < LOG2N; b++)
            if (((v >> b) & 1) != 0) o |= (1 << (LOG2N - 1 - b));
        return o;
    endfunction

    function automatic logic [15:0] ashr(input logic [15:0] v, input int s);
        logic signed [15:0] t;
        t = v;
        return t >>> s;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL N=%0d %s: actual %0h expected %0h", N, tag, act, exp);
        end
    endtask

    task automatic fill_all();
        for (int r = 0; r < 8; r++) begin
            for (int a = 0; a < N; a++) begin
                @(negedge clk);
                mre[r][a] = 16'($urandom);
                mim[r][a] = 16'($urandom);
                fill_we = 1; fill_row = 3'(r); fill_addr = LOG2N'(a);
                fill_re = mre[r][a]; fill_im = mim[r][a];
            end
        end
        @(negedge clk);
        fill_we = 0;
    endtask

    task automatic model_apply(input bit scl, input int s);
        logic [15:0] tr [8][N];
        logic [15:0] ti [8][N];
        for (int r = 0; r < 8; r++)
            for (int j = 0; j < N; j++) begin
                tr[r][j] = scl ? ashr(mre[r][brev(j)], s) : mre[r][brev(j)];
                ti[r][j] = scl ? ashr(mim[r][brev(j)], s) : mim[r][brev(j)];
            end
        mre = tr;
        mim = ti;
    endtask

    task automatic push_all();
        exp_t e;
        for (int r = 0; r < 8; r++)
            for (int a = 0; a < N; a++) begin
                e.row = r; e.addr = a; e.re = mre[r][a]; e.im = mim[r][a];
                q.push_back(e);
            end
    endtask

    // Monitor side of the scoreboard: pop each expected item and compare it with the read port.
    task automatic drain(input string tag);
        exp_t e;
        while (q.size() > 0) begin
            e = q.pop_front();
            @(negedge clk);
            rd_row = 3'(e.row); rd_addr = LOG2N'(e.addr);
            #1;
            chk({rd_re, rd_im} === {e.re, e.im}, tag, {rd_re, rd_im}, {e.re, e.im});
        end
    endtask

    task automatic run(input bit mode, input int sh, input bit disturb);
        int n;
        int s_cnt = 0;
        for (int i = 0; i < N; i++) if (brev(i) > i) s_cnt++;
        @(negedge clk);
        start = 1; row_mode = mode; shift_amt = SHW'(sh);
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 0;
        chk(busy === 1'b1, "R7 busy after start", {31'b0, busy}, 32'd1);
        if (disturb) begin
            // R7 R8 R9: restart attempt, config change and fill write while busy
            start = 1; row_mode = !mode; shift_amt = SHW'(1);
            fill_we = 1; fill_row = 0; fill_addr = '0; fill_re = 16'h7ffe; fill_im = 16'h8001;
        end
        while (!done && n < 4 * N + 16) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 2) begin
                start = 0; fill_we = 0; row_mode = mode; shift_amt = SHW'(sh);
            end
        end
        chk(done === 1'b1 && n == N + s_cnt + 1, "R6 done edge", n, N + s_cnt + 1);
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R6 R7 idle after done", {30'b0, busy, done}, 32'd0);
    endtask

    initial begin
        int smax;
        fin = 0; errs = 0; chks = 0;
        start = 0; row_mode = 0; shift_amt = '0; fill_we = 0;
        fill_row = '0; fill_addr = '0; fill_re = '0; fill_im = '0;
        rd_row = '0; rd_addr = '0;
        @(negedge clk);
        while (rst !== 1'b0) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset state", {30'b0, busy, done}, 32'd0);

        // R2 R5 with R7 R8 R9 disturbances mid-run
        fill_all();
        run(0, 0, 1);
        model_apply(0, 0);
        push_all();
        drain("R2 R5 R7 R8 R9 reorder");

        // R3 scaled reorder
        fill_all();
        run(1, (LOG2N > 1) ? 2 : 1, 0);
        model_apply(1, (LOG2N > 1) ? 2 : 1);
        push_all();
        drain("R3 scale");

        // R4 shift clamp
        smax = (1 << SHW) - 1;
        fill_all();
        run(1, smax, 0);
        model_apply(1, (smax > LOG2N) ? LOG2N : smax);
        push_all();
        drain("R4 clamp");

        // R10 zero shift in scale mode
        fill_all();
        run(1, 0, 0);
        model_apply(0, 0);
        push_all();
        drain("R10 zero shift");

        // R11 double reorder returns original
        fill_all();
        run(0, 0, 0);
        run(0, 0, 0);
        push_all();
        drain("R11 involution");

        fin = 1;
    end
endmodule

module bitrev_reorder_tb;
    logic clk = 0;
    logic rst = 1;
    logic f8, f64, f512;
    int   e8, e64, e512, c8, c64, c512;
    int   err_t, chk_t;

    always #5 clk = ~clk;

    brr_harness #(.LOG2N(3)) u_h8   (.clk(clk), .rst(rst), .fin(f8),   .errs(e8),   .chks(c8));
    brr_harness #(.LOG2N(6)) u_h64  (.clk(clk), .rst(rst), .fin(f64),  .errs(e64),  .chks(c64));
    brr_harness #(.LOG2N(9)) u_h512 (.clk(clk), .rst(rst), .fin(f512), .errs(e512), .chks(c512));

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
    end

    initial begin
        bit timeout = 0;
        fork
            begin
                wait (f8 === 1'b1 && f64 === 1'b1 && f512 === 1'b1);
            end
            begin
                repeat (190000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        err_t = e8 + e64 + e512;
        chk_t = c8 + c64 + c512;
        if (timeout) begin
            err_t++;
            chk_t++;
            $display("FAIL watchdog: actual not finished expected finished");
        end
        $display("Result: errors=%0d of %0d checks", err_t, chk_t);
        $finish;
    end
endmodule